// File: doc/BRIEF.md
# Space-Vector Switching Sequencer

This block turns a sector index and two precomputed active-vector dwell times into the three pole commands of a two-level, three-leg inverter for each switching cycle. A free-running counter marks out the cycle. At every cycle boundary the block samples the sector, both dwell times, the cycle length and the mode select. From these it works out, for each leg, the count at which that leg first toggles. The matching second toggle falls at the mirror count, so every pulse is centred in the cycle.

Two sequences are available. The symmetric mode uses seven segments. The zero time is shared: one quarter sits at each end of the cycle in state 000, and the remaining half sits in the centre in state 111. The bus-clamped mode uses five segments and one zero vector: 111 in odd sectors and 000 in even sectors. In this mode one leg does not switch for the whole cycle. If the two dwell times together exceed the cycle, they are scaled down so that they fill the cycle exactly. The per-leg toggle counts are also brought out as ports, so the sequence can be checked from outside.

Top module: `svm_sequencer`

## Requirements
- R1: While reset is held, and until the first cycle starts, the poles read 000, the cycle start flag is high, and all three toggle counts read 1.
- R2: The cycle length is the sampled length input, with an input of 0 taken as 1. The internal tick counter runs from 0 to length-1 and then wraps. The cycle start output is high exactly on tick 0.
- R3: The pole bus is pole[2]=A, pole[1]=B, pole[0]=C, and 1 means the upper switch is on. Sector k (1..6) is bounded by the vectors V(k) and V(k mod 6 + 1), with V1..V6 = 100,110,010,011,001,101. In symmetric mode, let Z=floor(T0/4), where T0 = length - Tm - Tn. Let u be the bounding vector with an odd index, and w the other one. The cycle then runs 000 for Z ticks, u for floor(Tu/2), w for floor(Tw/2), 111 for the remainder, w for floor(Tw/2), u for floor(Tu/2), and 000 for Z ticks. Tm is the dwell of V(k) and Tn is the dwell of V(k mod 6 + 1).
- R4: When every segment of a cycle lasts at least one tick, consecutive ticks inside that cycle differ in at most one pole.
- R5: In bus-clamped mode with an odd sector, let Y=floor(T0/2). The cycle runs 111 for Y ticks, V(k mod 6 + 1) for floor(Tn/2), V(k) for the remainder, V(k mod 6 + 1) for floor(Tn/2), and 111 for Y ticks. One pole therefore never leaves 1.
- R6: In bus-clamped mode with an even sector, the cycle has the same shape as in R5 but with 000 as the zero vector. One pole therefore never leaves 0.
- R7: If Tm+Tn exceeds the cycle length L, Tm is replaced by floor(Tm*L/(Tm+Tn)) and Tn by L minus that value, so T0 is 0.
- R8: Sector, dwell times, cycle length and mode are sampled only on the clock edge that starts a cycle. A change made in the middle of a cycle has no effect on the poles or toggle counts until the next cycle starts.
- R9: The toggle count of each leg gives the tick, counted from the cycle start, at which the first segment begins whose vector differs from the cycle's zero vector in that leg. If the leg never differs from the zero vector, the count equals the cycle length.
- R10: A sector value of 0 or 7 gives poles 000 for the whole cycle, and all toggle counts equal the cycle length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sector | input | 3 | Sector index, 1 to 6 |
| dwell_m | input | TW | Dwell ticks of the first bounding vector |
| dwell_n | input | TW | Dwell ticks of the second bounding vector |
| cycle_len | input | TW | Switching cycle length in ticks |
| clamp_en | input | 1 | 1 selects bus-clamped mode, 0 selects symmetric mode |
| pole | output | 3 | Pole commands {A,B,C} |
| cycle_start | output | 1 | High on the first tick of each cycle |
| on_a | output | TW | Toggle count of leg A |
| on_b | output | TW | Toggle count of leg B |
| on_c | output | TW | Toggle count of leg C |

## Verification
The bench compares every port on every tick, so a wrong internal state shows up at once. A wrong tick counter or cycle length shifts cycle_start within one cycle. A wrong latched toggle count or polarity appears on the toggle-count ports on the first tick after the cycle boundary, and on the pole bus at the next edge of that leg. A wrong order table for a sector shows up as a wrong pole within floor(T0/4)+1 ticks of the cycle start. A wrong sampling point shows up as a mid-cycle change of the toggle counts.

// File: rtl/svm_seq_pkg.sv
package svm_seq_pkg;

   typedef logic [1:0] rank_t;

   // order in which each leg leaves the 000 state, packed {A,B,C}
   function automatic rank_t leg_rank(input logic [2:0] sec, input int unsigned leg);
      logic [5:0] r;
      case (sec)
         3'd1:    r = {2'd0, 2'd1, 2'd2};
         3'd2:    r = {2'd1, 2'd0, 2'd2};
         3'd3:    r = {2'd2, 2'd0, 2'd1};
         3'd4:    r = {2'd2, 2'd1, 2'd0};
         3'd5:    r = {2'd1, 2'd2, 2'd0};
         3'd6:    r = {2'd0, 2'd2, 2'd1};
         default: r = {2'd0, 2'd1, 2'd2};
      endcase
      return r[(2 - leg) * 2 +: 2];
   endfunction

endpackage

// File: rtl/svm_cycle_timer.sv
module svm_cycle_timer #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [TW-1:0] per_i,
   output logic [TW-1:0] cnt_o,
   output logic [TW-1:0] per_o,
   output logic          wrap_o,
   output logic          start_o
);
   localparam logic [TW-1:0] ONE = {{(TW-1){1'b0}}, 1'b1};

   logic [TW-1:0] cnt_q, per_q;

   assign wrap_o  = (cnt_q >= per_q - ONE);
   assign start_o = (cnt_q == '0);
   assign cnt_o   = cnt_q;
   assign per_o   = per_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         per_q <= ONE;
      end else if (wrap_o) begin
         cnt_q <= '0;
         per_q <= per_i;
      end else begin
         cnt_q <= cnt_q + ONE;
      end
   end

   AST_CNT_BELOW_PER: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < per_q);  // R2

endmodule

// File: rtl/svm_dwell_limit.sv
module svm_dwell_limit #(
   parameter int TW = 8
) (
   input  logic [TW-1:0] ta_i,
   input  logic [TW-1:0] tb_i,
   input  logic [TW-1:0] len_i,
   output logic [TW-1:0] ta_o,
   output logic [TW-1:0] tb_o,
   output logic [TW-1:0] t0_o,
   output logic [TW-1:0] per_o
);
   localparam int PW = 2 * TW;

   logic [TW:0]   sum;
   logic [PW-1:0] prod, quot;
   logic          over, sat;
   logic [TW-1:0] ta_sc;

   assign per_o = (len_i == '0) ? {{(TW-1){1'b0}}, 1'b1} : len_i;
   assign sum   = {1'b0, ta_i} + {1'b0, tb_i};
   assign over  = sum > {1'b0, per_o};
   assign prod  = {{TW{1'b0}}, ta_i} * {{TW{1'b0}}, per_o};
   assign quot  = prod / {{(TW-1){1'b0}}, sum};
   assign sat   = |quot[PW-1:TW];
   assign ta_sc = sat ? per_o : quot[TW-1:0];

   assign ta_o = over ? ta_sc : ta_i;
   assign tb_o = over ? (per_o - ta_sc) : tb_i;
   assign t0_o = per_o - ta_o - tb_o;

endmodule

// File: rtl/svm_leg_plan.sv
module svm_leg_plan
   import svm_seq_pkg::*;
#(
   parameter int TW  = 8,
   parameter int LEG = 0
) (
   input  logic [2:0]    sec_i,
   input  logic          clamp_i,
   input  logic [TW-1:0] ta_i,
   input  logic [TW-1:0] tb_i,
   input  logic [TW-1:0] t0_i,
   input  logic [TW-1:0] per_i,
   output logic [TW-1:0] dly_o,
   output logic          inv_o
);
   rank_t         rk;
   logic          valid, odd;
   logic [TW-1:0] z4, z2, h_near, h_far, h_n;

   assign rk     = leg_rank(sec_i, LEG);
   assign valid  = (sec_i != 3'd0) && (sec_i != 3'd7);
   assign odd    = sec_i[0];
   assign z4     = t0_i >> 2;
   assign z2     = t0_i >> 1;
   assign h_near = odd ? (ta_i >> 1) : (tb_i >> 1);
   assign h_far  = odd ? (tb_i >> 1) : (ta_i >> 1);
   assign h_n    = tb_i >> 1;

   always_comb begin
      dly_o = per_i;
      inv_o = 1'b0;
      if (!valid) begin
         dly_o = per_i;
      end else if (!clamp_i) begin
         case (rk)
            2'd0:    dly_o = z4;
            2'd1:    dly_o = z4 + h_near;
            default: dly_o = z4 + h_near + h_far;
         endcase
      end else if (odd) begin
         inv_o = 1'b1;
         case (rk)
            2'd2:    dly_o = z2;
            2'd1:    dly_o = z2 + h_n;
            default: dly_o = per_i;
         endcase
      end else begin
         case (rk)
            2'd0:    dly_o = z2;
            2'd1:    dly_o = z2 + h_n;
            default: dly_o = per_i;
         endcase
      end
   end

endmodule

// File: rtl/svm_pole_gen.sv
module svm_pole_gen #(
   parameter int TW   = 8,
   parameter int LEGS = 3
) (
   input  logic [TW-1:0]           cnt_i,
   input  logic [TW-1:0]           per_i,
   input  logic [LEGS-1:0][TW-1:0] dly_i,
   input  logic [LEGS-1:0]         inv_i,
   output logic [LEGS-1:0]         pole_o
);
   for (genvar g = 0; g < LEGS; g++) begin : g_leg
      logic in_win;
      assign in_win = (cnt_i >= dly_i[g]) && (cnt_i < per_i - dly_i[g]);
      assign pole_o[LEGS-1-g] = inv_i[g] ^ in_win;
   end
endmodule

// File: rtl/svm_sequencer.sv
module svm_sequencer #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [2:0]    sector,
   input  logic [TW-1:0] dwell_m,
   input  logic [TW-1:0] dwell_n,
   input  logic [TW-1:0] cycle_len,
   input  logic          clamp_en,
   output logic [2:0]    pole,
   output logic          cycle_start,
   output logic [TW-1:0] on_a,
   output logic [TW-1:0] on_b,
   output logic [TW-1:0] on_c
);
   localparam int LEGS = 3;
   localparam logic [TW-1:0] ONE = {{(TW-1){1'b0}}, 1'b1};

   if (TW < 4) begin : g_bad_tw
      $error("svm_sequencer: TW must be at least 4");
   end

   logic [TW-1:0] cnt, per_q, per_eff, ta_l, tb_l, t0_l;
   logic          wrap;
   logic [LEGS-1:0][TW-1:0] dly_d, dly_q;
   logic [LEGS-1:0]         inv_d, inv_q;
   logic          clamp_q, odd_q, valid_q;

   svm_cycle_timer #(.TW(TW)) i_timer (
      .clk(clk), .rst_n(rst_n), .per_i(per_eff),
      .cnt_o(cnt), .per_o(per_q), .wrap_o(wrap), .start_o(cycle_start));

   svm_dwell_limit #(.TW(TW)) i_limit (
      .ta_i(dwell_m), .tb_i(dwell_n), .len_i(cycle_len),
      .ta_o(ta_l), .tb_o(tb_l), .t0_o(t0_l), .per_o(per_eff));

   for (genvar g = 0; g < LEGS; g++) begin : g_plan
      svm_leg_plan #(.TW(TW), .LEG(g)) i_plan (
         .sec_i(sector), .clamp_i(clamp_en), .ta_i(ta_l), .tb_i(tb_l),
         .t0_i(t0_l), .per_i(per_eff), .dly_o(dly_d[g]), .inv_o(inv_d[g]));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dly_q   <= {LEGS{ONE}};
         inv_q   <= '0;
         clamp_q <= 1'b0;
         odd_q   <= 1'b0;
         valid_q <= 1'b0;
      end else if (wrap) begin
         dly_q   <= dly_d;
         inv_q   <= inv_d;
         clamp_q <= clamp_en;
         odd_q   <= sector[0];
         valid_q <= (sector != 3'd0) && (sector != 3'd7);
      end
   end

   svm_pole_gen #(.TW(TW), .LEGS(LEGS)) i_poles (
      .cnt_i(cnt), .per_i(per_q), .dly_i(dly_q), .inv_i(inv_q), .pole_o(pole));

   assign on_a = dly_q[0];
   assign on_b = dly_q[1];
   assign on_c = dly_q[2];

   AST_INSTANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap |=> $stable(dly_q));  // R8
   AST_INSTANT_FIT: assert property (@(posedge clk) disable iff (!rst_n)
      (dly_q[0] <= per_q) && (dly_q[1] <= per_q) && (dly_q[2] <= per_q));  // R9
   AST_CLAMP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (clamp_q && odd_q && valid_q) |-> (pole != 3'b000));  // R5
   AST_CLAMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (clamp_q && !odd_q && valid_q) |-> (pole != 3'b111));  // R6
   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_q |-> (pole == 3'b000));  // R10

endmodule

// File: tb/test_svm_sequencer.sv
`timescale 1ns/1ps
module test_svm_sequencer;
   localparam int TW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [2:0] sector = 3'd1;
   logic [TW-1:0] dwell_m = '0, dwell_n = '0, cycle_len = 8'd40;
   logic clamp_en = 1'b0;
   logic [2:0] pole;
   logic cycle_start;
   logic [TW-1:0] on_a, on_b, on_c;

   svm_sequencer #(.TW(TW)) i_svm_sequencer (
      .clk(clk), .rst_n(rst_n), .sector(sector), .dwell_m(dwell_m),
      .dwell_n(dwell_n), .cycle_len(cycle_len), .clamp_en(clamp_en),
      .pole(pole), .cycle_start(cycle_start), .on_a(on_a), .on_b(on_b), .on_c(on_c));

   always #2 clk = ~clk;

   int vectors = 0, fails = 0;
   bit done = 0;
   string cur_req = "R1";
   bit step_chk = 0;
   logic [2:0] prev_pole = 3'b000;

   int m_tick = 0, m_per = 1;
   logic [2:0] m_seq[$];
   int m_on[3];

   function automatic logic [2:0] vec_of(input int k);
      case (k)
         1: return 3'b100;  2: return 3'b110;  3: return 3'b010;
         4: return 3'b011;  5: return 3'b001;  default: return 3'b101;
      endcase
   endfunction

   // build the expected per-tick pole list and toggle counts for one cycle
   task automatic build_cycle();
      int per, ta, tb, t0, z, s;
      logic [2:0] zero, first, second, u, w;
      int tu, tw;
      logic [2:0] sv[$];
      int sd[$];
      per = (cycle_len == 0) ? 1 : int'(cycle_len);
      ta = int'(dwell_m); tb = int'(dwell_n);
      if (ta + tb > per) begin   // R7 scaling
         ta = (ta * per) / (ta + tb);
         tb = per - ta;
      end
      t0 = per - ta - tb;
      s = int'(sector);
      zero = 3'b000;
      if (s < 1 || s > 6) begin
         sv.push_back(3'b000); sd.push_back(per);
      end else begin
         first = vec_of(s); second = vec_of(s % 6 + 1);
         if (!clamp_en) begin
            u  = (s % 2 == 1) ? first : second;
            w  = (s % 2 == 1) ? second : first;
            tu = (s % 2 == 1) ? ta : tb;
            tw = (s % 2 == 1) ? tb : ta;
            z  = t0 / 4;
            sv = '{3'b000, u, w, 3'b111, w, u, 3'b000};
            sd = '{z, tu/2, tw/2, per - 2*(z + tu/2 + tw/2), tw/2, tu/2, z};
         end else begin
            zero = (s % 2 == 1) ? 3'b111 : 3'b000;
            z  = t0 / 2;
            sv = '{zero, second, first, second, zero};
            sd = '{z, tb/2, per - 2*(z + tb/2), tb/2, z};
         end
      end
      m_seq.delete();
      foreach (sv[i]) for (int r = 0; r < sd[i]; r++) m_seq.push_back(sv[i]);
      for (int leg = 0; leg < 3; leg++) begin
         int cum = 0;
         bit found = 0;
         m_on[leg] = per;
         foreach (sv[i]) begin
            if (!found && sv[i][2-leg] != zero[2-leg]) begin
               m_on[leg] = cum; found = 1;
            end
            cum += sd[i];
         end
      end
      m_per = per;
   endtask

   task automatic check_now();
      logic [2:0] ep;
      ep = m_seq[m_tick];
      vectors++;
      if (pole !== ep) begin
         fails++; $display("FAIL %s tick %0d pole got %b exp %b", cur_req, m_tick, pole, ep);
      end
      if (cycle_start !== (m_tick == 0)) begin
         fails++; $display("FAIL R2 cycle_start got %b exp %b", cycle_start, m_tick == 0);
      end
      if (int'(on_a) != m_on[0] || int'(on_b) != m_on[1] || int'(on_c) != m_on[2]) begin
         fails++;
         $display("FAIL R9 (%s) toggle counts got %0d/%0d/%0d exp %0d/%0d/%0d", cur_req,
                  on_a, on_b, on_c, m_on[0], m_on[1], m_on[2]);
      end
      if (step_chk && m_tick != 0 && $countones(pole ^ prev_pole) > 1) begin
         fails++; $display("FAIL R4 tick %0d pole got %b after %b exp one change", m_tick, pole, prev_pole);
      end
      prev_pole = pole;
   endtask

   task automatic tick(input int n);
      for (int k = 0; k < n; k++) begin
         if (m_tick >= m_per - 1) begin
            build_cycle();
            m_tick = 0;
         end else m_tick++;
         @(negedge clk);
         check_now();
      end
   endtask

   task automatic setup(input int sec, input int ta, input int tb, input int len, input bit clamp);
      sector = 3'(sec); dwell_m = TW'(ta); dwell_n = TW'(tb);
      cycle_len = TW'(len); clamp_en = clamp;
   endtask

   initial begin
      m_seq = '{3'b000};
      m_on = '{1, 1, 1};
      @(negedge clk); @(negedge clk);
      cur_req = "R1";
      check_now();                 // R1 reset state
      rst_n = 1'b1;

      // R3 symmetric sweep over all sectors, R4 single-pole steps
      step_chk = 1;
      cur_req = "R3";
      for (int s = 1; s <= 6; s++) begin
         setup(s, 10, 12, 40, 0);
         tick(90);
      end
      // R5 clamped odd sectors, R6 clamped even sectors
      for (int s = 1; s <= 6; s++) begin
         cur_req = (s % 2 == 1) ? "R5" : "R6";
         setup(s, 10, 12, 40, 1);
         tick(90);
      end
      step_chk = 0;

      // R7 over-range scaling
      cur_req = "R7";
      setup(2, 30, 30, 40, 0); tick(90);
      setup(3, 25, 20, 40, 1); tick(90);
      setup(5, 200, 9, 40, 0); tick(90);

      // R2 cycle length handling, including 0 and odd lengths
      cur_req = "R2";
      setup(1, 1, 2, 7, 0);  tick(20);
      setup(4, 3, 3, 0, 0);  tick(10);
      setup(6, 2, 5, 13, 1); tick(30);

      // R9 boundary dwell values
      cur_req = "R9";
      setup(1, 0, 0, 40, 0);   tick(90);
      setup(2, 20, 20, 40, 0); tick(90);
      setup(3, 19, 21, 40, 1); tick(90);

      // R8 change inputs mid-cycle
      cur_req = "R8";
      setup(1, 10, 12, 40, 0); tick(90);
      while (m_tick != 15) tick(1);
      setup(4, 20, 6, 30, 1); tick(70);
      while (m_tick != 5) tick(1);
      setup(5, 8, 8, 50, 0); tick(100);

      // R10 invalid sector values
      cur_req = "R10";
      setup(0, 10, 12, 40, 0); tick(90);
      setup(7, 10, 12, 40, 1); tick(90);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      #800000;
      if (!done) begin
         fails++;
         $display("FAIL R2 watchdog expired, run did not complete");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

endmodule